// File: doc/BRIEF.md
# Random Bit-Stream Health Monitor

This block watches the raw output of an entropy source and flags it when it looks broken. Bits arrive one per strobe; each accepted bit feeds three tests at once. A frequency test counts ones over consecutive 20,000-bit windows. Two run detectors watch for runs of equal bits: a shorter limit of 34 and a longer extreme limit of 48. A fourth test watches the conditioned output words. Each output word is 128 bits wide, and the test flags a word that repeats the word accepted just before it.

Each test drives its own failure output. Every output is a one-cycle pulse, and a register stage elsewhere holds it sticky for software. The enable input gates the whole block: while it is low every test returns to its idle state and clears its counters. Every detector is a small state machine. The frequency test has two states, Idle and Counting. It moves from Idle to Counting on enable and returns to Idle when enable drops. Each run detector has three states: Idle (no previous bit), Tracking (a run below the limit) and Fired (the limit was reached). The moves are Idle to Tracking on the first bit, Tracking to Fired when the run reaches its limit, and Fired back to Tracking when the bit value changes. Every state returns to Idle when enable drops. The word test has two states, Idle (no stored word) and Holding. It moves from Idle to Holding on the first word and returns to Idle when enable drops.

Top module: `rng_health_mon`

## Requirements
- R1: After reset all four failure outputs are low.
- R2: Accepted bits are taken in windows of 20,000. When the last bit of a window is accepted and the window held fewer than 9,655 ones or more than 10,345 ones, monobit_fail is high for exactly the next cycle. The bounds 9,655 and 10,345 themselves pass.
- R3: The ones count and the bit count restart at zero after every window, so each window is judged only on its own bits.
- R4: longrun_fail pulses for one cycle in the cycle after the 34th consecutive equal accepted bit.
- R5: noise_fail pulses for one cycle in the cycle after the 48th consecutive equal accepted bit.
- R6: Each run detector pulses at most once per run. A run ends when an accepted bit differs from the previous accepted bit, and the run length restarts at 1 on that bit.
- R7: stuck_fail pulses for one cycle in the cycle after an accepted word equals, in all 128 bits, the previously accepted word.
- R8: The first word accepted after reset or after enable rises never raises stuck_fail.
- R9: While en is low, all counters and stored values are cleared, strobes are ignored, and no failure output is high in the following cycle.
- R10: A cycle with bit_vld low changes no bit test; bits on either side of it join into the same run and the same window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Monitor enable; low clears all tests |
| bit_vld | input | 1 | Strobe marking bit_in as a new stream bit |
| bit_in | input | 1 | Serial random bit |
| word_vld | input | 1 | Strobe marking word_in as a new output word |
| word_in | input | 128 | Output word to compare with its predecessor |
| monobit_fail | output | 1 | Pulse: window ones count out of range |
| longrun_fail | output | 1 | Pulse: run of 34 equal bits |
| noise_fail | output | 1 | Pulse: run of 48 equal bits |
| stuck_fail | output | 1 | Pulse: repeated output word |

## Verification
The hardest behaviour to reach is the exact pass/fail edge of the frequency test. A random stream essentially never lands within one bit of either bound, and every attempt costs a full 20,000-bit window. The stimulus therefore builds whole windows with an exact ones count: 9,654, 9,655, 10,345 and 10,346. The ones are spread evenly so that no run detector triggers. One of these windows is followed at once by a random window, which shows that the count restarts. Long and extreme runs, enable drops in mid-run, gaps in the strobe, and repeated words drawn from a three-value set are driven as directed cases and as seeded random traffic.

// File: rtl/rng_hm_pkg.sv
package rng_hm_pkg;

    typedef enum logic {
        MB_IDLE,
        MB_COUNT
    } mb_state_e;

    typedef enum logic [1:0] {
        RUN_IDLE,
        RUN_TRACK,
        RUN_FIRED
    } run_state_e;

    typedef enum logic {
        SK_IDLE,
        SK_HOLD
    } sk_state_e;

endpackage

// File: rtl/rng_hm_monobit.sv
module rng_hm_monobit
    import rng_hm_pkg::*;
#(
    parameter int WIN = 20000,
    parameter int LO  = 9655,
    parameter int HI  = 10345
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bit_vld,
    input  logic bit_in,
    output logic fail_o
);
    localparam int CW = $clog2(WIN + 1);

    mb_state_e      state_q;
    logic [CW-1:0]  bit_cnt_q;
    logic [CW-1:0]  ones_q;
    logic           take;
    logic           last;
    logic [CW-1:0]  ones_nx;
    logic           oob;
    logic           fail_q;

    always_comb begin
        take    = en && bit_vld;
        ones_nx = ones_q + CW'(bit_in);
        last    = take && (bit_cnt_q == CW'(WIN - 1));
        oob     = (ones_nx < CW'(LO)) || (ones_nx > CW'(HI));
    end

    // state and counters
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state_q   <= MB_IDLE;
            bit_cnt_q <= '0;
            ones_q    <= '0;
        end else begin
            unique case (state_q)
                MB_IDLE: begin
                    state_q <= MB_COUNT;
                    if (take) begin
                        bit_cnt_q <= CW'(1);
                        ones_q    <= CW'(bit_in);
                    end
                end
                MB_COUNT: begin
                    if (last) begin
                        bit_cnt_q <= '0;
                        ones_q    <= '0;
                    end else if (take) begin
                        bit_cnt_q <= bit_cnt_q + CW'(1);
                        ones_q    <= ones_nx;
                    end
                end
                default: state_q <= MB_IDLE;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) fail_q <= 1'b0;
        else        fail_q <= last && oob;
    end

    assign fail_o = fail_q;
endmodule

// File: rtl/rng_hm_run.sv
module rng_hm_run
    import rng_hm_pkg::*;
#(
    parameter int RUN_LEN = 34
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bit_vld,
    input  logic bit_in,
    output logic fail_o
);
    localparam int LW = $clog2(RUN_LEN + 1);

    run_state_e     state_q;
    logic           prev_q;
    logic [LW-1:0]  len_q;
    logic           take;
    logic           same;
    logic           hit;
    logic           fail_q;

    always_comb begin
        take = en && bit_vld;
        same = (bit_in == prev_q);
        hit  = take && (state_q == RUN_TRACK) && same
               && (len_q == LW'(RUN_LEN - 1));
    end

    // state, last bit and run length
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state_q <= RUN_IDLE;
            prev_q  <= 1'b0;
            len_q   <= '0;
        end else if (take) begin
            unique case (state_q)
                RUN_IDLE: begin
                    state_q <= RUN_TRACK;
                    prev_q  <= bit_in;
                    len_q   <= LW'(1);
                end
                RUN_TRACK: begin
                    if (!same) begin
                        prev_q <= bit_in;
                        len_q  <= LW'(1);
                    end else if (len_q == LW'(RUN_LEN - 1)) begin
                        state_q <= RUN_FIRED;
                        len_q   <= LW'(RUN_LEN);
                    end else begin
                        len_q <= len_q + LW'(1);
                    end
                end
                RUN_FIRED: begin
                    if (!same) begin
                        state_q <= RUN_TRACK;
                        prev_q  <= bit_in;
                        len_q   <= LW'(1);
                    end
                end
                default: state_q <= RUN_IDLE;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) fail_q <= 1'b0;
        else        fail_q <= hit;
    end

    assign fail_o = fail_q;
endmodule

// File: rtl/rng_hm_stuck.sv
module rng_hm_stuck
    import rng_hm_pkg::*;
#(
    parameter int WORD_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_in,
    output logic              fail_o
);
    sk_state_e          state_q;
    logic [WORD_W-1:0]  last_q;
    logic               take;
    logic               hit;
    logic               fail_q;

    always_comb begin
        take = en && word_vld;
        hit  = take && (state_q == SK_HOLD) && (word_in == last_q);
    end

    // state and stored word
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state_q <= SK_IDLE;
            last_q  <= '0;
        end else if (take) begin
            unique case (state_q)
                SK_IDLE: begin
                    state_q <= SK_HOLD;
                    last_q  <= word_in;
                end
                SK_HOLD: last_q <= word_in;
                default: state_q <= SK_IDLE;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) fail_q <= 1'b0;
        else        fail_q <= hit;
    end

    assign fail_o = fail_q;
endmodule

// File: rtl/rng_health_mon.sv
module rng_health_mon #(
    parameter int WIN       = 20000,
    parameter int MONO_LO   = 9655,
    parameter int MONO_HI   = 10345,
    parameter int LONG_RUN  = 34,
    parameter int NOISE_RUN = 48,
    parameter int WORD_W    = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_in,
    output logic              monobit_fail,
    output logic              longrun_fail,
    output logic              noise_fail,
    output logic              stuck_fail
);
    localparam int NRUN = 2;
    localparam int RUN_LIMIT [NRUN] = '{LONG_RUN, NOISE_RUN};

    logic [NRUN-1:0] run_fail;

    rng_hm_monobit #(.WIN(WIN), .LO(MONO_LO), .HI(MONO_HI)) i_monobit (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .fail_o  (monobit_fail)
    );

    for (genvar g = 0; g < NRUN; g++) begin : g_run
        rng_hm_run #(.RUN_LEN(RUN_LIMIT[g])) i_run (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en),
            .bit_vld (bit_vld),
            .bit_in  (bit_in),
            .fail_o  (run_fail[g])
        );
    end

    assign longrun_fail = run_fail[0];
    assign noise_fail   = run_fail[1];

    rng_hm_stuck #(.WORD_W(WORD_W)) i_stuck (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .word_vld (word_vld),
        .word_in  (word_in),
        .fail_o   (stuck_fail)
    );
endmodule

// File: rtl/rng_health_mon_chk.sv
module rng_health_mon_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic bit_vld,
    input logic word_vld,
    input logic monobit_fail,
    input logic longrun_fail,
    input logic noise_fail,
    input logic stuck_fail
);
    a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(monobit_fail || longrun_fail || noise_fail || stuck_fail));

    a_r10_no_bit_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> !(monobit_fail || longrun_fail || noise_fail));

    a_r6_long_single: assert property (@(posedge clk) disable iff (!rst_n)
        longrun_fail |=> !longrun_fail);

    a_r6_noise_single: assert property (@(posedge clk) disable iff (!rst_n)
        noise_fail |=> !noise_fail);

    a_r2_mono_single: assert property (@(posedge clk) disable iff (!rst_n)
        monobit_fail |=> !monobit_fail);

    a_r7_stuck_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> !stuck_fail);
endmodule

bind rng_health_mon rng_health_mon_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .bit_vld      (bit_vld),
    .word_vld     (word_vld),
    .monobit_fail (monobit_fail),
    .longrun_fail (longrun_fail),
    .noise_fail   (noise_fail),
    .stuck_fail   (stuck_fail)
);

// File: tb/test_rng_health_mon.sv
`timescale 1ns/1ps
module test_rng_health_mon;
    localparam int WIN = 20000;
    localparam int LO  = 9655;
    localparam int HI  = 10345;
    localparam int LR  = 34;
    localparam int NR  = 48;
    localparam int WW  = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          bit_vld = 1'b0;
    logic          bit_in = 1'b0;
    logic          word_vld = 1'b0;
    logic [WW-1:0] word_in = '0;
    logic          monobit_fail, longrun_fail, noise_fail, stuck_fail;

    int checks = 0;
    int errors = 0;
    int n_mono = 0, n_long = 0, n_noise = 0, n_stuck = 0;

    // reference model state
    int            m_cnt = 0, m_ones = 0, m_len = 0;
    bit            m_prev = 1'b0, m_have = 1'b0, m_whave = 1'b0;
    logic [WW-1:0] m_word = '0;

    always #10 clk = ~clk;

    rng_health_mon i_rng_health_mon (
        .clk, .rst_n, .en, .bit_vld, .bit_in, .word_vld, .word_in,
        .monobit_fail, .longrun_fail, .noise_fail, .stuck_fail
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit mono_out_of_range(input int ones);
        return (ones < LO) || (ones > HI);
    endfunction

    task automatic step(input bit e, input bit bv, input bit b,
                        input bit wv, input logic [WW-1:0] w);
        bit xm = 0, xl = 0, xn = 0, xs = 0;
        en = e; bit_vld = bv; bit_in = b; word_vld = wv; word_in = w;
        if (!e) begin
            m_cnt = 0; m_ones = 0; m_len = 0; m_have = 0; m_whave = 0;
        end else begin
            if (bv) begin
                m_cnt++;
                m_ones += int'(b);
                if (m_cnt == WIN) begin
                    xm = mono_out_of_range(m_ones);
                    m_cnt = 0; m_ones = 0;
                end
                if (m_have && b == m_prev) m_len++;
                else m_len = 1;
                m_prev = b; m_have = 1;
                xl = (m_len == LR);
                xn = (m_len == NR);
            end
            if (wv) begin
                xs = m_whave && (w == m_word);
                m_word = w; m_whave = 1;
            end
        end
        @(posedge clk); #1;
        if (e) begin
            check(monobit_fail === xm, "R2 monobit pulse", int'(monobit_fail), int'(xm));
            check(longrun_fail === xl, "R4 long-run pulse", int'(longrun_fail), int'(xl));
            check(noise_fail === xn, "R5 noise pulse", int'(noise_fail), int'(xn));
            check(stuck_fail === xs, "R7 stuck pulse", int'(stuck_fail), int'(xs));
        end else begin
            check({monobit_fail, longrun_fail, noise_fail, stuck_fail} === 4'b0,
                  "R9 outputs while disabled",
                  int'({monobit_fail, longrun_fail, noise_fail, stuck_fail}), 0);
        end
        n_mono  += int'(monobit_fail === 1'b1);
        n_long  += int'(longrun_fail === 1'b1);
        n_noise += int'(noise_fail === 1'b1);
        n_stuck += int'(stuck_fail === 1'b1);
    endtask

    task automatic run_of(input bit b, input int n);
        for (int i = 0; i < n; i++) step(1, 1, b, 0, '0);
    endtask

    task automatic even_window(input int k);
        for (int i = 0; i < WIN; i++)
            step(1, 1, ((i + 1) * k / WIN) != (i * k / WIN), 0, '0);
    endtask

    function automatic logic [WW-1:0] pick_word(input int sel);
        return {WW/32{32'hA5C3_0000 + 32'(sel)}};
    endfunction

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int base;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check({monobit_fail, longrun_fail, noise_fail, stuck_fail} === 4'b0,
              "R1 reset outputs", int'({monobit_fail, longrun_fail, noise_fail, stuck_fail}), 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0, '0);
        check({monobit_fail, longrun_fail, noise_fail, stuck_fail} === 4'b0,
              "R1 after reset release", int'({monobit_fail, longrun_fail, noise_fail, stuck_fail}), 0);

        // R4 R5 R6: one run of 50 ones fires each detector once
        base = n_long;
        run_of(1, 50);
        check(n_long - base == 1, "R6 long-run single pulse per run", n_long - base, 1);
        check(n_noise == 1, "R6 noise single pulse per run", n_noise, 1);
        // R6: change restarts run length at 1
        step(1, 1, 0, 0, '0);
        run_of(1, 34);
        check(n_long - base == 2, "R6 restart after value change", n_long - base, 2);

        // R10: gaps do not break a run
        step(1, 1, 0, 0, '0);
        base = n_long;
        run_of(1, 30);
        for (int i = 0; i < 10; i++) step(1, 0, 0, 0, '0);
        run_of(1, 4);
        check(n_long - base == 1, "R10 run spans idle strobes", n_long - base, 1);

        // R9: enable drop clears the run
        step(1, 1, 0, 0, '0);
        base = n_long;
        run_of(1, 30);
        step(0, 1, 1, 1, pick_word(1));
        step(0, 1, 1, 1, pick_word(1));
        run_of(1, 10);
        check(n_long - base == 0, "R9 disable clears run length", n_long - base, 0);

        // R7 R8: repeated words
        base = n_stuck;
        step(1, 0, 0, 1, pick_word(5));
        step(1, 0, 0, 1, pick_word(5));
        check(n_stuck - base == 1, "R7 repeat detected", n_stuck - base, 1);
        step(1, 0, 0, 1, pick_word(6));
        step(1, 0, 0, 0, pick_word(6));
        step(1, 0, 0, 1, pick_word(5));
        check(n_stuck - base == 1, "R7 distinct words pass", n_stuck - base, 1);
        step(0, 0, 0, 0, '0);
        step(1, 0, 0, 1, pick_word(5));
        check(n_stuck - base == 1, "R8 first word after enable", n_stuck - base, 1);

        // seeded random mix of words, bits and enable
        for (int i = 0; i < 3000; i++) begin
            bit e = ($urandom % 64) != 0;
            step(e, ($urandom % 4) != 0, ($urandom % 8) != 0,
                 ($urandom % 2) != 0, pick_word(int'($urandom % 3)));
        end

        // R2: exact boundaries, each from a fresh window
        step(0, 0, 0, 0, '0);
        base = n_mono; even_window(LO - 1);
        check(n_mono - base == 1, "R2 below lower bound fails", n_mono - base, 1);
        step(0, 0, 0, 0, '0);
        base = n_mono; even_window(LO);
        check(n_mono - base == 0, "R2 lower bound passes", n_mono - base, 0);
        step(0, 0, 0, 0, '0);
        base = n_mono; even_window(HI);
        check(n_mono - base == 0, "R2 upper bound passes", n_mono - base, 0);
        step(0, 0, 0, 0, '0);
        base = n_mono; even_window(HI + 1);
        check(n_mono - base == 1, "R2 above upper bound fails", n_mono - base, 1);

        // R3: next window starts from zero, random near-balanced bits
        base = n_mono;
        begin
            int got = 0;
            while (got < WIN) begin
                bit v = ($urandom % 8) != 0;
                step(1, v, $urandom % 2 == 1, 0, '0);
                got += int'(v);
            end
        end
        check(n_mono - base == 0, "R3 window restart after failing window", n_mono - base, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule